// File: doc/BRIEF.md
# SDRAM Refresh Request Timer

This block tells an SDRAM command sequencer when an auto-refresh is due. A two-bit rate code chooses one of three refresh periods or switches refresh off, and a two-bit frequency code states which of three bus clock speeds the controller runs at. The block turns the chosen period into a clock cycle count for that speed and counts cycles. Each time a period runs out, it adds one to a pending-refresh count.

The request output stays high while any refresh is pending. The sequencer pulses an acknowledge once for each refresh it has carried out. Pending refreshes are queued up to a ceiling, so a sequencer that is held off by long bursts can catch up later. The block does not issue commands and does not sequence precharge or refresh; it only says when a refresh is due.

Top module: `sdram_refresh_timer`

## Requirements
- R1: While reset is asserted and on the first cycle after it, the request output is 0 and the pending count is 0. After reset the interval counter starts from zero and the stored configuration is "refresh off".
- R2: With rate code 2'b00, no interval ever expires and the pending count never rises. An acknowledge still removes pending refreshes while refresh is off.
- R3: Rate code 2'b01 selects 7.8 us, 2'b10 selects 15.6 us and 2'b11 selects 125 us. The period in cycles is floor(f x t). Frequency code 2'b00 is 66 MHz, 2'b01 is 100 MHz and 2'b10 is 133 MHz. This gives 514/1029/8250 cycles at 66 MHz, 780/1560/12500 at 100 MHz and 1037/2074/16625 at 133 MHz. The first increment of the pending count lands exactly that many rising edges after the edge that registers the new configuration.
- R4: Frequency code 2'b11 uses the 66 MHz cycle counts, which are the shortest and therefore the safe choice.
- R5: While the configuration stays the same, later expiries follow one another exactly one period apart.
- R6: Each expiry adds one to the pending count, which saturates at 8.
- R7: An acknowledge subtracts one from a nonzero pending count. An acknowledge when the count is zero is ignored. An acknowledge in the same cycle as an expiry leaves a nonzero count unchanged.
- R8: The request output is 1 exactly when the pending count is nonzero.
- R9: Any change of the rate code or the frequency code restarts the interval from zero. Pending refreshes are kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rate_sel_i | input | 2 | Refresh period code: 00 off, 01 7.8 us, 10 15.6 us, 11 125 us |
| freq_sel_i | input | 2 | Bus clock code: 00 66 MHz, 01 100 MHz, 10 133 MHz, 11 treated as 66 MHz |
| ref_ack_i | input | 1 | One-cycle pulse per refresh performed by the sequencer |
| ref_req_o | output | 1 | Refresh wanted (pending count nonzero) |
| ref_pend_o | output | 4 | Number of refreshes owed, 0 to 8 |

## Verification
The assertions assume that the acknowledge is a one-cycle pulse given once per refresh actually carried out. They also assume that the configuration inputs are synchronous to the bus clock, so a change is seen on exactly one edge.

The bench drives the acknowledge only at falling edges and holds it for a single cycle. It changes the rate and frequency codes only at falling edges. Each directed scenario starts from a disabled, drained state, so the expected cycle counts follow from the configuration edge alone.

// File: rtl/sdram_refresh_pkg.sv
package sdram_refresh_pkg;

    typedef enum logic [1:0] {
        RATE_OFF   = 2'b00,
        RATE_SHORT = 2'b01,
        RATE_MID   = 2'b10,
        RATE_LONG  = 2'b11
    } rate_e;

    typedef struct packed {
        logic [1:0] rate;
        logic [1:0] freq;
    } cfg_t;

    // Cycles in one period, rounded down so refresh is never late.
    function automatic int unsigned interval_cycles(input int unsigned khz,
                                                    input int unsigned ns);
        longint unsigned prod;
        prod = 64'(khz) * 64'(ns);
        return int'(prod / 64'd1000000);
    endfunction

    function automatic int unsigned longest_interval(
        input int unsigned f0, input int unsigned f1, input int unsigned f2,
        input int unsigned t1, input int unsigned t2, input int unsigned t3);
        int unsigned fk [3];
        int unsigned tn [3];
        int unsigned best;
        fk = '{f0, f1, f2};
        tn = '{t1, t2, t3};
        best = 1;
        for (int i = 0; i < 3; i++) begin
            for (int j = 0; j < 3; j++) begin
                if (interval_cycles(fk[i], tn[j]) > best)
                    best = interval_cycles(fk[i], tn[j]);
            end
        end
        return best;
    endfunction

endpackage

// File: rtl/sdram_refresh_interval_sel.sv
module sdram_refresh_interval_sel
    import sdram_refresh_pkg::*;
#(
    parameter int unsigned FREQ0_KHZ = 66000,
    parameter int unsigned FREQ1_KHZ = 100000,
    parameter int unsigned FREQ2_KHZ = 133000,
    parameter int unsigned PER1_NS   = 7800,
    parameter int unsigned PER2_NS   = 15600,
    parameter int unsigned PER3_NS   = 125000,
    parameter int unsigned CW        = 15
) (
    input  cfg_t          cfg_i,
    output logic [CW-1:0] term_o,
    output logic          en_o
);

    localparam int unsigned NFREQ = 3;
    localparam int unsigned NPER  = 3;
    localparam int unsigned FK [NFREQ] = '{FREQ0_KHZ, FREQ1_KHZ, FREQ2_KHZ};
    localparam int unsigned TN [NPER]  = '{PER1_NS, PER2_NS, PER3_NS};

    logic [CW-1:0] tbl [NFREQ][NPER];

    for (genvar gf = 0; gf < NFREQ; gf++) begin : g_freq
        for (genvar gp = 0; gp < NPER; gp++) begin : g_per
            assign tbl[gf][gp] = CW'(interval_cycles(FK[gf], TN[gp]));
        end
    end

    logic [1:0] fidx;
    logic [1:0] pidx;

    always_comb begin
        // Unknown frequency code falls back to the slowest clock: shortest count.
        fidx   = (cfg_i.freq == 2'b11) ? 2'b00 : cfg_i.freq;
        pidx   = 2'b00;
        en_o   = 1'b0;
        term_o = '0;
        case (rate_e'(cfg_i.rate))
            RATE_SHORT: begin pidx = 2'd0; en_o = 1'b1; end
            RATE_MID:   begin pidx = 2'd1; en_o = 1'b1; end
            RATE_LONG:  begin pidx = 2'd2; en_o = 1'b1; end
            default:    begin pidx = 2'd0; en_o = 1'b0; end
        endcase
        if (en_o)
            term_o = tbl[fidx][pidx];
    end

endmodule

// File: rtl/sdram_refresh_interval_timer.sv
module sdram_refresh_interval_timer
    import sdram_refresh_pkg::*;
#(
    parameter int unsigned CW = 15
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  cfg_t          cfg_i,
    input  logic [CW-1:0] term_i,
    input  logic          en_i,
    output cfg_t          cfg_q_o,
    output logic          tick_o
);

    typedef struct packed {
        cfg_t          cfg;
        logic [CW-1:0] cnt;
    } tmr_state_t;

    tmr_state_t st_d, st_q;
    logic       changed;

    always_comb begin
        st_d     = st_q;
        tick_o   = 1'b0;
        changed  = (cfg_i != st_q.cfg);
        st_d.cfg = cfg_i;
        if (changed) begin
            st_d.cnt = '0;
        end else if (!en_i) begin
            st_d.cnt = '0;
        end else if (st_q.cnt == term_i - CW'(1)) begin
            st_d.cnt = '0;
            tick_o   = 1'b1;
        end else begin
            st_d.cnt = st_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.cfg <= '{rate: RATE_OFF, freq: 2'b00};
            st_q.cnt <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_q_o = st_q.cfg;

    AST_CNT_BELOW_TERM: assert property (@(posedge clk_i) disable iff (!rst_ni)
        en_i |-> (st_q.cnt < term_i)); // R3
    AST_RELOAD_ON_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cfg_i != st_q.cfg) |=> (st_q.cnt == '0)); // R9
    AST_OFF_NO_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.cfg.rate == RATE_OFF) |-> !tick_o); // R2
    AST_TICK_AT_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> (st_q.cnt == '0)); // R5

endmodule

// File: rtl/sdram_refresh_pending.sv
module sdram_refresh_pending #(
    parameter int unsigned PEND_MAX = 8,
    parameter int unsigned PW       = 4
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          tick_i,
    input  logic          ack_i,
    output logic [PW-1:0] cnt_o,
    output logic          req_o
);

    typedef struct packed {
        logic [PW-1:0] cnt;
    } pend_state_t;

    pend_state_t st_d, st_q;
    logic        take;

    always_comb begin
        st_d = st_q;
        take = ack_i && (st_q.cnt != '0);
        case ({tick_i, take})
            2'b10: if (st_q.cnt != PW'(PEND_MAX)) st_d.cnt = st_q.cnt + PW'(1);
            2'b01: st_d.cnt = st_q.cnt - PW'(1);
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;
    assign req_o = (st_q.cnt != '0);

    AST_PEND_CEIL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.cnt <= PW'(PEND_MAX)); // R6
    AST_TICK_ADDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && !ack_i && st_q.cnt < PW'(PEND_MAX)) |=> (st_q.cnt == $past(st_q.cnt) + PW'(1))); // R6
    AST_ACK_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ack_i && !tick_i && st_q.cnt != '0) |=> (st_q.cnt == $past(st_q.cnt) - PW'(1))); // R7
    AST_IDLE_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ack_i && !tick_i && st_q.cnt == '0) |=> (st_q.cnt == '0)); // R7
    AST_BOTH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ack_i && tick_i && st_q.cnt != '0) |=> $stable(st_q.cnt)); // R7

endmodule

// File: rtl/sdram_refresh_timer.sv
module sdram_refresh_timer
    import sdram_refresh_pkg::*;
#(
    parameter int unsigned FREQ0_KHZ = 66000,
    parameter int unsigned FREQ1_KHZ = 100000,
    parameter int unsigned FREQ2_KHZ = 133000,
    parameter int unsigned PER1_NS   = 7800,
    parameter int unsigned PER2_NS   = 15600,
    parameter int unsigned PER3_NS   = 125000,
    parameter int unsigned PEND_MAX  = 8,
    localparam int unsigned PW = $clog2(PEND_MAX + 1)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic [1:0]    rate_sel_i,
    input  logic [1:0]    freq_sel_i,
    input  logic          ref_ack_i,
    output logic          ref_req_o,
    output logic [PW-1:0] ref_pend_o
);

    localparam int unsigned MAXCYC = longest_interval(FREQ0_KHZ, FREQ1_KHZ, FREQ2_KHZ,
                                                      PER1_NS, PER2_NS, PER3_NS);
    localparam int unsigned CW = $clog2(MAXCYC + 1);

    cfg_t          cfg_in;
    cfg_t          cfg_q;
    logic [CW-1:0] term;
    logic          en;
    logic          tick;

    assign cfg_in.rate = rate_sel_i;
    assign cfg_in.freq = freq_sel_i;

    sdram_refresh_interval_sel #(
        .FREQ0_KHZ (FREQ0_KHZ),
        .FREQ1_KHZ (FREQ1_KHZ),
        .FREQ2_KHZ (FREQ2_KHZ),
        .PER1_NS   (PER1_NS),
        .PER2_NS   (PER2_NS),
        .PER3_NS   (PER3_NS),
        .CW        (CW)
    ) sel_i (
        .cfg_i  (cfg_q),
        .term_o (term),
        .en_o   (en)
    );

    sdram_refresh_interval_timer #(
        .CW (CW)
    ) tmr_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .cfg_i   (cfg_in),
        .term_i  (term),
        .en_i    (en),
        .cfg_q_o (cfg_q),
        .tick_o  (tick)
    );

    sdram_refresh_pending #(
        .PEND_MAX (PEND_MAX),
        .PW       (PW)
    ) pend_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .tick_i (tick),
        .ack_i  (ref_ack_i),
        .cnt_o  (ref_pend_o),
        .req_o  (ref_req_o)
    );

    AST_REQ_TRACKS_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ref_req_o == (ref_pend_o != '0)); // R8
    AST_OFF_NO_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cfg_q.rate == RATE_OFF && rate_sel_i == RATE_OFF) |=> (ref_pend_o <= $past(ref_pend_o))); // R2

endmodule

// File: tb/sdram_refresh_timer_tb_top.sv
module sdram_refresh_timer_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] rate_sel = 2'b00;
    logic [1:0] freq_sel = 2'b00;
    logic       ack = 1'b0;
    logic       req;
    logic [3:0] pend;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    localparam int LIMIT = 40000;

    always #2 clk = ~clk;

    sdram_refresh_timer dut_i (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .rate_sel_i (rate_sel),
        .freq_sel_i (freq_sel),
        .ref_ack_i  (ack),
        .ref_req_o  (req),
        .ref_pend_o (pend)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic apply_cfg(input logic [1:0] r, input logic [1:0] f);
        @(negedge clk);
        rate_sel = r;
        freq_sel = f;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wait_level(input int target, output int n);
        n = 0;
        while (pend < target && n < LIMIT) begin
            @(posedge clk);
            n++;
            @(negedge clk);
        end
    endtask

    task automatic pulse_ack();
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
    endtask

    task automatic drain_and_off();
        apply_cfg(2'b00, 2'b00);
        while (pend != 0) pulse_ack();
    endtask

    task automatic t_reset();
        check(req == 1'b0, "R1 req in reset", req, 0);
        check(pend == 0, "R1 pend in reset", pend, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(req == 1'b0, "R1 req after reset", req, 0);
        check(pend == 0, "R1 pend after reset", pend, 0);
    endtask

    task automatic t_interval(input logic [1:0] r, input logic [1:0] f, input int exp,
                              input string tag);
        int n;
        apply_cfg(r, f);
        wait_level(1, n);
        check(n == exp, tag, n, exp);
        check(req == 1'b1, "R8 req with one pending", req, 1);
        drain_and_off();
        check(req == 1'b0, "R8 req after drain", req, 0);
    endtask

    task automatic t_periodic();
        int n;
        apply_cfg(2'b01, 2'b01);
        wait_level(1, n);
        wait_level(2, n);
        check(n == 780, "R5 second period 100MHz 7.8us", n, 780);
        wait_level(3, n);
        check(n == 780, "R5 third period 100MHz 7.8us", n, 780);
        drain_and_off();
    endtask

    task automatic t_saturate();
        apply_cfg(2'b01, 2'b00);
        repeat (10 * 514 + 20) @(negedge clk);
        check(pend == 8, "R6 saturation at 8", pend, 8);
        apply_cfg(2'b00, 2'b00);
        for (int i = 7; i >= 0; i--) begin
            pulse_ack();
            check(pend == i, "R7 ack decrements", pend, i);
        end
        check(req == 1'b0, "R8 req low at zero", req, 0);
        pulse_ack();
        check(pend == 0, "R7 ack at zero ignored", pend, 0);
    endtask

    task automatic t_off_keeps();
        int n;
        apply_cfg(2'b01, 2'b00);
        wait_level(3, n);
        apply_cfg(2'b00, 2'b00);
        repeat (20000) @(negedge clk);
        check(pend == 3, "R2 no expiry while off, pending kept", pend, 3);
        pulse_ack();
        check(pend == 2, "R2 ack drains while off", pend, 2);
        drain_and_off();
    endtask

    task automatic t_change();
        int n;
        apply_cfg(2'b01, 2'b00);
        wait_level(1, n);
        repeat (300) @(negedge clk);
        apply_cfg(2'b10, 2'b00);
        check(pend == 1, "R9 pending kept on rate change", pend, 1);
        wait_level(2, n);
        check(n == 1029, "R9 restart after rate change", n, 1029);
        repeat (500) @(negedge clk);
        apply_cfg(2'b10, 2'b10);
        wait_level(3, n);
        check(n == 2074, "R9 restart after freq change", n, 2074);
        apply_cfg(2'b10, 2'b00);
        repeat (1028) @(negedge clk);
        check(pend == 3, "R7 before simultaneous ack", pend, 3);
        pulse_ack();
        check(pend == 3, "R7 expiry plus ack holds count", pend, 3);
        @(negedge clk);
        check(pend == 3, "R7 count steady after overlap", pend, 3);
        drain_and_off();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_interval(2'b01, 2'b00, 514,   "R3 66MHz 7.8us");
        t_interval(2'b01, 2'b01, 780,   "R3 100MHz 7.8us");
        t_interval(2'b01, 2'b10, 1037,  "R3 133MHz 7.8us");
        t_interval(2'b10, 2'b00, 1029,  "R3 66MHz 15.6us");
        t_interval(2'b10, 2'b10, 2074,  "R3 133MHz 15.6us");
        t_interval(2'b11, 2'b00, 8250,  "R3 66MHz 125us");
        t_interval(2'b11, 2'b01, 12500, "R3 100MHz 125us");
        t_interval(2'b11, 2'b10, 16625, "R3 133MHz 125us");
        t_interval(2'b01, 2'b11, 514,   "R4 code 11 as 66MHz 7.8us");
        t_interval(2'b10, 2'b11, 1029,  "R4 code 11 as 66MHz 15.6us");
        t_periodic();
        t_saturate();
        t_off_keeps();
        t_change();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule